// File: doc/BRIEF.md
# Serial-In Parallel-Out Register with Capture Latch

This block accepts one bit per rising edge of a shift clock into a chain of stages, and copies the whole chain at once into a holding register on a rising edge of a separate capture clock. The holding register drives a set of parallel lines. An active-low enable lets those lines float, so several sources can share the lines. The last stage of the chain is always present on a serial output, so several of these blocks can be linked end to end into one longer chain.

The shift chain has an active-low asynchronous clear. The clear does not reach the holding register. If the shift and capture clocks share one edge, the holding register takes the chain as it was before that edge, so it stays one shift behind. The holding register has no reset. Its contents are unknown until the first capture edge.

Top module: `sipo_latch_reg`

## Requirements
- R1: On each rising edge of `clk_shift`, while `rst_shift_n` is high, stage 0 takes `ser_in` and stage k takes the old value of stage k-1 for k from 1 to STAGES-1. Stage k maps to parallel line `par_out[k]`.
- R2: `ser_out` always equals stage STAGES-1. After a shift edge it therefore carries the value that stage STAGES-2 held before that edge.
- R3: On each rising edge of `clk_store`, all stages are copied together into the holding register, with stage k going to bit k.
- R4: Driving `rst_shift_n` low clears every stage at once, without waiting for a clock edge. It leaves the holding register, and so `par_out`, unchanged.
- R5: A rising edge of `clk_store` while `rst_shift_n` is low loads all zeros into the holding register.
- R6: While `oe_n` is high, `par_out` is high impedance and `par_hiz` is 1. While `oe_n` is low, `par_out` drives the holding register and `par_hiz` is 0.
- R7: `oe_n` has no effect on `ser_out`, on the shift stages or on the holding register. After enabling again, `par_out` shows the contents it would have shown without the disabled interval.
- R8: If `clk_shift` and `clk_store` rise together, the holding register takes the stage values from before that edge.
- R9: The stage count is the parameter STAGES, with a default of 8. Feeding one block's `ser_out` into the `ser_in` of the next block forms a single chain whose length is the sum of the stage counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_shift | input | 1 | Shift clock, rising edge active |
| clk_store | input | 1 | Capture clock for the holding register, rising edge active |
| rst_shift_n | input | 1 | Active-low asynchronous clear of the shift stages only |
| oe_n | input | 1 | Active-low enable for the parallel lines |
| ser_in | input | 1 | Serial data into stage 0 |
| ser_out | output | 1 | Last shift stage, used for chaining |
| par_out | output | STAGES | Holding register contents, or high impedance |
| par_hiz | output | 1 | High while the parallel lines are released |

## Verification
The bench builds two instances: one with the default STAGES of 8, and one with STAGES of 5 whose serial input is the first instance's `ser_out`. Because the two stage counts differ, a bit-order error, a wrong tap point or an off-by-one in the chain shows up at a different place in each instance. Using a short second instance also makes a full 13-bit path through both blocks quick to cover. One reference model of the combined 13-bit chain predicts both holding registers and both serial outputs. This covers a clear in the middle of a shift sequence, capture edges taken during the clear, and capture edges that coincide with shift edges.

// File: rtl/sipo_pkg.sv
`timescale 1ns/1ps
package sipo_pkg;
   // Smallest chain for which "second to last stage" is a distinct stage.
   localparam int unsigned SIPO_MIN_STAGES = 2;
   localparam int unsigned SIPO_MAX_STAGES = 1024;
endpackage

// File: rtl/sipo_shift_chain.sv
`timescale 1ns/1ps
module sipo_shift_chain #(
   parameter int unsigned STAGES = 8
) (
   input  logic              clk_shift,
   input  logic              rst_shift_n,
   input  logic              ser_in,
   output logic [STAGES-1:0] stage_q
);
   localparam int unsigned LAST = STAGES - 1;

   logic [STAGES:0] link;
   assign link[0] = ser_in;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk_shift or negedge rst_shift_n) begin
         if (!rst_shift_n) stage_q[k] <= 1'b0;
         else              stage_q[k] <= link[k];
      end
      assign link[k+1] = stage_q[k];
   end

   logic unused_tail;
   assign unused_tail = link[LAST+1];
endmodule

// File: rtl/sipo_hold_reg.sv
`timescale 1ns/1ps
module sipo_hold_reg #(
   parameter int unsigned STAGES = 8
) (
   input  logic              clk_store,
   input  logic [STAGES-1:0] stage_q,
   output logic [STAGES-1:0] hold_q
);
   // Deliberately no reset: contents are undefined until the first capture.
   always_ff @(posedge clk_store) begin
      hold_q <= stage_q;
   end
endmodule

// File: rtl/sipo_out_drv.sv
`timescale 1ns/1ps
module sipo_out_drv #(
   parameter int unsigned STAGES = 8
) (
   input  logic              oe_n,
   input  logic [STAGES-1:0] hold_q,
   output logic [STAGES-1:0] par_out,
   output logic              par_hiz
);
   for (genvar k = 0; k < STAGES; k++) begin : g_pad
      assign par_out[k] = oe_n ? 1'bz : hold_q[k];
   end
   assign par_hiz = oe_n;
endmodule

// File: rtl/sipo_latch_reg.sv
`timescale 1ns/1ps
module sipo_latch_reg
   import sipo_pkg::*;
#(
   parameter int unsigned STAGES = 8
) (
   input  logic              clk_shift,
   input  logic              clk_store,
   input  logic              rst_shift_n,
   input  logic              oe_n,
   input  logic              ser_in,
   output logic              ser_out,
   output logic [STAGES-1:0] par_out,
   output logic              par_hiz
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < SIPO_MIN_STAGES || STAGES > SIPO_MAX_STAGES) begin : g_bad_stages
      $error("sipo_latch_reg: STAGES out of supported range");
   end

   logic [STAGES-1:0] shift_q;
   logic [STAGES-1:0] store_q;

   sipo_shift_chain #(.STAGES(STAGES)) u_chain (
      .clk_shift   (clk_shift),
      .rst_shift_n (rst_shift_n),
      .ser_in      (ser_in),
      .stage_q     (shift_q)
   );

   sipo_hold_reg #(.STAGES(STAGES)) u_hold (
      .clk_store (clk_store),
      .stage_q   (shift_q),
      .hold_q    (store_q)
   );

   sipo_out_drv #(.STAGES(STAGES)) u_drv (
      .oe_n    (oe_n),
      .hold_q  (store_q),
      .par_out (par_out),
      .par_hiz (par_hiz)
   );

   assign ser_out = shift_q[LAST];
endmodule

// File: rtl/sipo_latch_chk.sv
`timescale 1ns/1ps
module sipo_latch_chk #(
   parameter int unsigned STAGES = 8
) (
   input logic              clk_shift,
   input logic              clk_store,
   input logic              rst_shift_n,
   input logic              ser_in,
   input logic              ser_out,
   input logic [STAGES-1:0] shift_q,
   input logic [STAGES-1:0] store_q
);
   // Set by any clear, dropped at the next shift edge: marks an interval in
   // which the chain did not evolve purely by shifting.
   logic rst_seen;
   always_ff @(posedge clk_shift or negedge rst_shift_n) begin
      if (!rst_shift_n) rst_seen <= 1'b1;
      else              rst_seen <= 1'b0;
   end

   assert_stage0_load_R1: assert property (@(posedge clk_shift) disable iff (!rst_shift_n)
      !rst_seen |-> shift_q[0] == $past(ser_in));

   assert_stage_advance_R1: assert property (@(posedge clk_shift) disable iff (!rst_shift_n)
      !rst_seen |-> shift_q[STAGES-1:1] == $past(shift_q[STAGES-2:0]));

   assert_cascade_tap_R2: assert property (@(posedge clk_shift) disable iff (!rst_shift_n)
      !rst_seen |-> ser_out == $past(shift_q[STAGES-2]));

   assert_capture_copy_R3: assert property (@(posedge clk_store) disable iff (!rst_shift_n)
      1'b1 |=> store_q == $past(shift_q));

   // The holding register has no reset; the clear is the trigger here.
   assert_capture_in_clear_R5: assert property (@(posedge clk_store)
      !rst_shift_n |=> store_q == '0);
endmodule

bind sipo_latch_reg sipo_latch_chk #(.STAGES(STAGES)) u_chk (
   .clk_shift   (clk_shift),
   .clk_store   (clk_store),
   .rst_shift_n (rst_shift_n),
   .ser_in      (ser_in),
   .ser_out     (ser_out),
   .shift_q     (shift_q),
   .store_q     (store_q)
);

// File: tb/tb_sipo_latch_reg.sv
`timescale 1ns/1ps
module tb_sipo_latch_reg;
   localparam int unsigned NA = 8;
   localparam int unsigned NB = 5;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic clk_shift = 1'b0, clk_store = 1'b0, rst_n = 1'b0, oe_n = 1'b0, ser_in = 1'b0;
   logic          ser_a, ser_b, hiz_a, hiz_b;
   logic [NA-1:0] par_a;
   logic [NB-1:0] par_b;

   sipo_latch_reg #(.STAGES(NA)) dut (
      .clk_shift(clk_shift), .clk_store(clk_store), .rst_shift_n(rst_n), .oe_n(oe_n),
      .ser_in(ser_in), .ser_out(ser_a), .par_out(par_a), .par_hiz(hiz_a));

   sipo_latch_reg #(.STAGES(NB)) dut_b (
      .clk_shift(clk_shift), .clk_store(clk_store), .rst_shift_n(rst_n), .oe_n(oe_n),
      .ser_in(ser_a), .ser_out(ser_b), .par_out(par_b), .par_hiz(hiz_b));

   typedef struct {
      logic [NA-1:0] pa;
      logic [NB-1:0] pb;
      logic          soa, sob, hiz, chk_par;
      string         tag;
   } exp_t;

   exp_t exp_q[$];
   int vectors = 0, miscompares = 0;
   bit done = 1'b0;

   // Reference model of the combined chain
   logic [NA-1:0] m_sa = '0, m_hold_a = '0;
   logic [NB-1:0] m_sb = '0, m_hold_b = '0;
   bit m_hold_valid = 1'b0;

   task automatic push(input string tag);
      exp_t e;
      e.pa = m_hold_a; e.pb = m_hold_b;
      e.soa = m_sa[NA-1]; e.sob = m_sb[NB-1];
      e.hiz = oe_n; e.chk_par = m_hold_valid; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic op(input logic s, input bit sh, input bit st, input logic oe, input string tag);
      logic [NB-1:0] nb;
      @(negedge clk);
      ser_in = s; oe_n = oe;
      @(posedge clk);
      clk_shift = sh; clk_store = st;
      if (st) begin
         m_hold_a = m_sa; m_hold_b = m_sb; m_hold_valid = 1'b1;
      end
      if (sh && rst_n) begin
         nb = {m_sb[NB-2:0], m_sa[NA-1]};
         m_sa = {m_sa[NA-2:0], s};
         m_sb = nb;
      end
      push(tag);
      @(negedge clk);
      clk_shift = 1'b0; clk_store = 1'b0;
   endtask

   task automatic set_rst(input logic v, input string tag);
      @(negedge clk);
      rst_n = v;
      if (!v) begin m_sa = '0; m_sb = '0; end
      push(tag);
   endtask

   task automatic cmp(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   // Monitor: pops one expectation per driver step, samples away from edges
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            cmp(e.tag, "par_hiz_a (R6)", {15'd0, hiz_a}, {15'd0, e.hiz});
            cmp(e.tag, "par_hiz_b (R6)", {15'd0, hiz_b}, {15'd0, e.hiz});
            cmp(e.tag, "ser_out_a (R2)", {15'd0, ser_a}, {15'd0, e.soa});
            cmp(e.tag, "ser_out_b (R9)", {15'd0, ser_b}, {15'd0, e.sob});
            if (!e.hiz && e.chk_par) begin
               cmp(e.tag, "par_out_a (R3)", {8'd0, par_a}, {8'd0, e.pa});
               cmp(e.tag, "par_out_b (R9)", {11'd0, par_b}, {11'd0, e.pb});
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         miscompares++;
         vectors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   localparam logic [12:0] PAT_A = 13'b1011_0010_1110_1;
   localparam logic [12:0] PAT_B = 13'b0110_1001_1100_1;

   initial begin
      // R5: capture while the clear is held gives an all-zero holding register
      set_rst(1'b0, "reset_state_R4");
      op(1'b1, 1'b1, 1'b1, 1'b0, "capture_in_clear_R5");
      set_rst(1'b1, "release");
      // R1 R2 R9: walk a pattern through the full 13-stage chain
      for (int i = 0; i < 13; i++) op(PAT_A[i], 1'b1, 1'b0, 1'b0, "shift_R1");
      op(1'b0, 1'b0, 1'b1, 1'b0, "capture_R3");
      // R6 R7: disabled lines, shifting and capturing continue unseen
      op(1'b0, 1'b0, 1'b0, 1'b1, "release_lines_R6");
      for (int i = 0; i < 4; i++) op(PAT_B[i], 1'b1, 1'b0, 1'b1, "shift_while_off_R7");
      op(1'b0, 1'b0, 1'b0, 1'b0, "reenable_unchanged_R7");
      op(1'b0, 1'b0, 1'b1, 1'b1, "capture_while_off_R7");
      op(1'b0, 1'b0, 1'b0, 1'b0, "reenable_after_capture_R7");
      // R8: shared edge, holding register lags by one
      for (int i = 0; i < 10; i++) op(PAT_B[i], 1'b1, 1'b1, 1'b0, "same_edge_R8");
      // R4: clear in the middle of a shift sequence
      for (int i = 0; i < 3; i++) op(1'b1, 1'b1, 1'b0, 1'b0, "pre_clear_shift_R1");
      set_rst(1'b0, "mid_clear_R4");
      op(1'b1, 1'b1, 1'b0, 1'b0, "shift_blocked_in_clear_R4");
      set_rst(1'b1, "release_R4");
      for (int i = 0; i < 9; i++) op(PAT_A[i], 1'b1, 1'b0, 1'b0, "shift_after_clear_R1");
      op(1'b0, 1'b0, 1'b1, 1'b0, "capture_after_clear_R3");
      // R5 again with non-zero holding contents before
      set_rst(1'b0, "clear_keeps_hold_R4");
      op(1'b0, 1'b0, 1'b1, 1'b0, "capture_in_clear_again_R5");
      set_rst(1'b1, "final_release");
      op(1'b1, 1'b1, 1'b0, 1'b0, "final_shift_R1");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule